// File: doc/BRIEF.md
# Real-Time-Clock Time-Base Divider

This block turns a fast oscillator enable into the slow time base of a real-time clock. Each enable pulse advances a binary divider chain of `STAGES` stages. A 3-bit select input bypasses a number of the leading stages, so the same chain can divide down several crystal frequencies to one update tick per second. Certain select codes instead hold the chain cleared and stop the tick. The live state of the chain is also brought out as a tap vector, which a periodic-interrupt selector downstream can use to pick a slower rate.

A build-time switch selects a reduced variant. In that variant only the lowest select bit is decoded: a zero selects the fixed bypass for a 32.768 kHz crystal, and a one stops the chain. The select input is a plain level, and the tick and taps are plain outputs. There is no handshake, because every output is a level or a pulse that the consumer samples on each cycle.

Top module: `rtcdiv_timebase`

## Requirements
- R1: During reset and in the first cycle after it, `sec_tick` is 0 and `taps` is all zeros.
- R2: In the full variant, select code 000 bypasses no stages, so `sec_tick` pulses once every 2^STAGES enabled cycles.
- R3: In the full variant, select code 001 bypasses `BYP_MID` stages, so `sec_tick` pulses once every 2^(STAGES-BYP_MID) enabled cycles.
- R4: In the full variant, select code 010 bypasses `BYP_HI` stages, so `sec_tick` pulses once every 2^(STAGES-BYP_HI) enabled cycles.
- R5: In the full variant, codes 011, 100, 101, 110 and 111 hold the chain. While the chain is held, `taps` stays all zeros and `sec_tick` never pulses.
- R6: `sec_tick` is high for exactly one cycle. It rises in the cycle after the enable that wraps the active stages, and `taps` reads zero in that cycle.
- R7: When the chain is released from a hold or a clear, the first tick comes exactly one full period later, counted in enabled cycles.
- R8: When the decoded bypass changes, the chain clears on the same clock edge. In the next cycle `taps` is zero and `sec_tick` is low.
- R9: A cycle with `osc_en` low leaves `taps` unchanged and produces no tick. Stalled cycles lengthen the period without resetting it.
- R10: In the reduced variant, `div_sel[0]`=0 selects bypass `BYP_HI` and `div_sel[0]`=1 holds the chain. The bits `div_sel[2:1]` are ignored, and changing them does not disturb the count.
- R11: Bit k of `taps` equals bit k of the number of enabled cycles since the last clear, counted modulo the period. Taps at or above the active stage count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator enable; each high cycle advances the chain once |
| div_sel | input | 3 | Divider select code |
| sec_tick | output | 1 | Single-cycle update pulse, once per period |
| taps | output | STAGES | State of the active divider stages, lowest stage in bit 0 |

## Verification
On every cycle the assertions check four things: the tick lasts a single cycle and lands on a zero count, a hold code keeps the outputs quiet, a select change clears the chain, and a stalled enable freezes the taps. Only the bench scenarios can show the exact period of each select code, the timing of the first tick after a release, the tap count after a known number of enables, and that in the reduced variant changing the upper select bits leaves a running count intact.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;

  // Number of leading stages skipped for a select code; "stages" means held.
  function automatic int unsigned sel_to_bypass(
    input logic [2:0]  sel,
    input int unsigned stages,
    input int unsigned mid,
    input int unsigned hi,
    input bit          reduced
  );
    int unsigned b;
    if (reduced) begin
      b = sel[0] ? stages : hi;
    end else begin
      case (sel)
        3'b000:  b = 0;
        3'b001:  b = mid;
        3'b010:  b = hi;
        default: b = stages;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/rtcdiv_sel_decode.sv
module rtcdiv_sel_decode #(
  parameter int unsigned STAGES  = 22,
  parameter int unsigned BYP_MID = 2,
  parameter int unsigned BYP_HI  = 7,
  parameter bit          REDUCED = 1'b0,
  localparam int unsigned BW     = $clog2(STAGES + 1)
) (
  input  logic [2:0]    sel,
  output logic [BW-1:0] bypass,
  output logic          hold
);
  import rtcdiv_pkg::*;

  generate
    if (REDUCED) begin : g_reduced
      always_comb begin
        bypass = BW'(sel_to_bypass({2'b00, sel[0]}, STAGES, BYP_MID, BYP_HI, 1'b1));
      end
    end else begin : g_full
      always_comb begin
        bypass = BW'(sel_to_bypass(sel, STAGES, BYP_MID, BYP_HI, 1'b0));
      end
    end
  endgenerate

  assign hold = (32'(bypass) >= STAGES);

endmodule

// File: rtl/rtcdiv_lane_mask.sv
module rtcdiv_lane_mask #(
  parameter int unsigned STAGES = 22,
  localparam int unsigned BW    = $clog2(STAGES + 1)
) (
  input  logic [BW-1:0]     bypass,
  output logic [STAGES-1:0] mask
);
  // Stage k of the active chain exists when k + bypass < STAGES.
  for (genvar k = 0; k < STAGES; k++) begin : g_lane
    localparam int unsigned K = k;
    assign mask[k] = (32'(bypass) + K) < STAGES;
  end
endmodule

// File: rtl/rtcdiv_chain.sv
module rtcdiv_chain #(
  parameter int unsigned STAGES = 22,
  localparam int unsigned BW    = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hold,
  input  logic [BW-1:0]     bypass,
  input  logic [STAGES-1:0] mask,
  output logic [STAGES-1:0] cnt,
  output logic              tick
);
  logic [BW-1:0]     byp_q;
  logic              sel_chg;
  logic              wrap;
  logic [STAGES-1:0] cnt_inc;

  assign sel_chg = (bypass != byp_q);
  assign wrap    = &(cnt | ~mask);
  assign cnt_inc = (cnt + {{(STAGES-1){1'b0}}, 1'b1}) & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_q <= '0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      byp_q <= bypass;
      if (hold || sel_chg) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (en) begin
        if (wrap) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt_inc;
          tick <= 1'b0;
        end
      end else begin
        tick <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtcdiv_timebase.sv
module rtcdiv_timebase #(
  parameter int unsigned STAGES  = 22,
  parameter int unsigned BYP_MID = 2,
  parameter int unsigned BYP_HI  = 7,
  parameter bit          REDUCED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic [2:0]        div_sel,
  output logic              sec_tick,
  output logic [STAGES-1:0] taps
);
  localparam int unsigned BW = $clog2(STAGES + 1);

  logic [BW-1:0]     bypass;
  logic              hold;
  logic [STAGES-1:0] mask;

  rtcdiv_sel_decode #(
    .STAGES(STAGES), .BYP_MID(BYP_MID), .BYP_HI(BYP_HI), .REDUCED(REDUCED)
  ) u_decode (
    .sel(div_sel), .bypass(bypass), .hold(hold)
  );

  rtcdiv_lane_mask #(.STAGES(STAGES)) u_mask (
    .bypass(bypass), .mask(mask)
  );

  rtcdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst_n(rst_n), .en(osc_en), .hold(hold),
    .bypass(bypass), .mask(mask), .cnt(taps), .tick(sec_tick)
  );
endmodule

// File: rtl/rtcdiv_timebase_chk.sv
module rtcdiv_timebase_chk #(
  parameter int unsigned STAGES  = 22,
  parameter bit          REDUCED = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_en,
  input logic [2:0]        div_sel,
  input logic              sec_tick,
  input logic [STAGES-1:0] taps
);
  logic [2:0] sel_d;
  logic       held_code;
  logic       sel_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_d <= 3'b000;
    else        sel_d <= div_sel;
  end

  generate
    if (REDUCED) begin : g_r
      assign held_code = div_sel[0];
      assign sel_moved = div_sel[0] != sel_d[0];
    end else begin : g_f
      assign held_code = div_sel[2] | (div_sel[1] & div_sel[0]);
      assign sel_moved = div_sel != sel_d;
    end
  endgenerate

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  assert_tick_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (taps == '0));

  // R5 and R10 hold behaviour
  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    held_code |=> (taps == '0) && !sec_tick);

  assert_change_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_moved |=> (taps == '0) && !sec_tick);

  assert_stall_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && div_sel == sel_d) |=> $stable(taps) && !sec_tick);
endmodule

bind rtcdiv_timebase rtcdiv_timebase_chk #(.STAGES(STAGES), .REDUCED(REDUCED)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .div_sel(div_sel),
  .sec_tick(sec_tick), .taps(taps)
);

// File: tb/rtcdiv_timebase_bench.sv
module rtcdiv_timebase_bench;
  localparam int N  = 10;
  localparam int BM = 2;
  localparam int BH = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         en;
  logic [2:0]   sel_a, sel_b;
  logic         tick_a, tick_b;
  logic [N-1:0] taps_a, taps_b;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  rtcdiv_timebase #(.STAGES(N), .BYP_MID(BM), .BYP_HI(BH), .REDUCED(1'b0)) u_rtcdiv_timebase (
    .clk(clk), .rst_n(rst_n), .osc_en(en), .div_sel(sel_a),
    .sec_tick(tick_a), .taps(taps_a)
  );

  rtcdiv_timebase #(.STAGES(N), .BYP_MID(BM), .BYP_HI(BH), .REDUCED(1'b1)) u_rtcdiv_timebase_lite (
    .clk(clk), .rst_n(rst_n), .osc_en(en), .div_sel(sel_b),
    .sec_tick(tick_b), .taps(taps_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic next_tick(input bit lite, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!(lite ? tick_b : tick_a) && n < 5000);
  endtask

  // The first edge after a select change clears rather than counts.
  task automatic first_tick(input bit lite, output int n);
    @(posedge clk);
    next_tick(lite, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    int byp;
    int per;
    logic [2:0] codes [8];
    codes = '{3'd1, 3'd2, 3'd0, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};

    rst_n = 1'b0; en = 1'b1; sel_a = 3'b000; sel_b = 3'b000;
    repeat (3) step();
    chk(tick_a == 1'b0 && taps_a == '0, "R1 reset full", int'(taps_a), 0);
    chk(tick_b == 1'b0 && taps_b == '0, "R1 reset reduced", int'(taps_b), 0);
    rst_n = 1'b1;
    step();
    chk(tick_a == 1'b0 && taps_a <= 1, "R1 after release", int'(taps_a), 1);

    // Sweep every select code of the full variant.
    foreach (codes[i]) begin
      sel_a = codes[i];
      byp = (codes[i] == 3'd0) ? 0 : (codes[i] == 3'd1) ? BM : (codes[i] == 3'd2) ? BH : N;
      if (byp == N) begin
        cnt = 0;
        for (int c = 0; c < 1100; c++) begin
          step();
          if (tick_a) cnt++;
        end
        chk(cnt == 0, "R5 hold code no tick", cnt, 0);
        chk(taps_a == '0, "R5 hold code taps zero", int'(taps_a), 0);
      end else begin
        per = 1 << (N - byp);
        first_tick(1'b0, n);
        chk(n == per, "R7 first tick after clear", n, per);
        next_tick(1'b0, n);
        if (codes[i] == 3'd0)      chk(n == per, "R2 period code 000", n, per);
        else if (codes[i] == 3'd1) chk(n == per, "R3 period code 001", n, per);
        else                       chk(n == per, "R4 period code 010", n, per);
        step();
        chk(tick_a == 1'b0, "R6 tick one cycle wide", int'(tick_a), 0);
        chk(taps_a == 1, "R11 taps one after wrap", int'(taps_a), 1);
      end
    end

    // Release from hold code 111 to 000.
    sel_a = 3'b000;
    first_tick(1'b0, n);
    chk(n == (1 << N), "R7 release from hold", n, 1 << N);

    // Tap counting and stall.
    sel_a = 3'b001;
    @(posedge clk);
    for (int c = 0; c < 100; c++) step();
    chk(taps_a == 100, "R11 taps after 100 enables", int'(taps_a), 100);
    en = 1'b0;
    cnt = 0;
    for (int c = 0; c < 40; c++) begin
      step();
      if (tick_a || taps_a != 100) cnt++;
    end
    chk(cnt == 0, "R9 stall freezes chain", cnt, 0);
    en = 1'b1;
    next_tick(1'b0, n);
    chk(n == (1 << (N - BM)) - 100, "R9 period resumes after stall", n, (1 << (N - BM)) - 100);

    // Mid-count select change.
    for (int c = 0; c < 50; c++) step();
    sel_a = 3'b010;
    step();
    chk(taps_a == '0 && !tick_a, "R8 change clears chain", int'(taps_a), 0);
    next_tick(1'b0, n);
    chk(n == (1 << (N - BH)), "R8 period after change", n, 1 << (N - BH));

    // Reduced variant.
    sel_b = 3'b001;
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      step();
      if (tick_b) cnt++;
    end
    chk(cnt == 0 && taps_b == '0, "R10 reduced bit0 one holds", cnt, 0);
    sel_b = 3'b110;
    first_tick(1'b1, n);
    chk(n == (1 << (N - BH)), "R10 reduced bit0 zero period", n, 1 << (N - BH));
    repeat (3) step();
    chk(taps_b == 3, "R10 reduced count before upper change", int'(taps_b), 3);
    sel_b = 3'b010;
    step();
    chk(taps_b == 4, "R10 upper select bits ignored", int'(taps_b), 4);
    next_tick(1'b1, n);
    chk(n == (1 << (N - BH)) - 4, "R10 period kept across upper change", n, (1 << (N - BH)) - 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule